// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block watches the stream of results from an analog-to-digital converter and decides, for every result, whether it lies in a programmed window. The window is set by a lower and an upper threshold. A mode input chooses how the window is applied. The comparison is signed when the converter runs differentially and unsigned when it runs single-ended. The result word and both thresholds are first cut down to the active resolution, which is 8, 10, 12 or 16 bits.

The block keeps a three-bit status word. Bit 0 says a result is ready, bit 1 says the window matched, and bit 2 says an overrun occurred. All three bits stay set until cleared. The block also drives two single-cycle event pulses, one for a window match and one for a ready result, and each has its own enable. The last result is held so that a reader can collect it. Reading it clears the ready bit.

Top module: `conv_window_monitor`

## Requirements
- R1: After reset, the status word, both event pulses and the held result are all zero.
- R2: A mode value of 0, or any value from 5 to 7, disables the monitor. In these modes no result ever sets status bit 1 or raises `win_evt`.
- R3: Mode 1 matches when the result is strictly greater than the lower threshold.
- R4: Mode 2 matches when the result is strictly less than the upper threshold.
- R5: Mode 3 matches when lower < result < upper, with both comparisons strict. Mode 4 matches exactly when mode 3 would not.
- R6: When `diff_mode` is 1, the result and both thresholds are compared as two's-complement values. When it is 0, they are compared as unsigned values.
- R7: `res_sel` selects the active width: 0 is 8 bits, 1 is 10 bits, 2 is 12 bits and 3 is 16 bits. Only the low bits within that width of the result and of each threshold are compared. In differential mode, the top bit of that width is the sign bit, whatever the higher bits hold.
- R8: A match on a cycle where `res_valid` is high sets status bit 1 at the next clock edge. If `win_evt_en` is 1, `win_evt` is also high for exactly that following cycle.
- R9: `res_valid` sets status bit 0 at the next edge. `rdy_evt` pulses in that cycle when `rdy_evt_en` is 1. A `res_read` strobe clears status bit 0 unless a new result arrives in the same cycle.
- R10: Status bit 2 is set when a result arrives while status bit 0 is still set and no `res_read` occurs in that cycle.
- R11: While `clr_we` is high, each 1 in `clr_bits` clears the matching status bit. If a set and a clear of the same bit happen in one cycle, the set wins.
- R12: `res_held` takes the raw result word at the edge that ends a `res_valid` cycle, and keeps it until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Right-adjusted conversion result |
| win_mode | input | 3 | Window mode select |
| thr_lo | input | 16 | Lower threshold |
| thr_hi | input | 16 | Upper threshold |
| res_sel | input | 2 | Active resolution select |
| diff_mode | input | 1 | 1 selects signed (differential) comparison |
| win_evt_en | input | 1 | Enables the window event pulse |
| rdy_evt_en | input | 1 | Enables the result-ready event pulse |
| res_read | input | 1 | Result read strobe |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 3 | Write-one-to-clear mask for the status bits |
| status | output | 3 | {overrun, window match, result ready} |
| win_evt | output | 1 | One-cycle window match event |
| rdy_evt | output | 1 | One-cycle result-ready event |
| res_held | output | 16 | Most recent result word |

## Verification
A fault in operand narrowing or in sign handling shows up only for particular resolution and mode pairings. It appears as a wrong `win_evt` exactly one cycle after the strobe, so every random result is checked at that cycle against a model of the comparison.

A sticky status bit that is lost or stuck is different. It stays visible on `status` until the next clear or read, so each directed case checks the whole status word before it clears it.

// File: rtl/conv_win_pkg.sv
package conv_win_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned CMP_W  = DATA_W + 1;
  localparam int unsigned ST_W   = 3;

  localparam int unsigned ST_RDY = 0;
  localparam int unsigned ST_WIN = 1;
  localparam int unsigned ST_OVR = 2;

  typedef enum logic [2:0] {
    WM_OFF     = 3'd0,
    WM_ABOVE   = 3'd1,
    WM_BELOW   = 3'd2,
    WM_INSIDE  = 3'd3,
    WM_OUTSIDE = 3'd4
  } win_mode_e;

  typedef enum logic [1:0] {
    RS_8  = 2'd0,
    RS_10 = 2'd1,
    RS_12 = 2'd2,
    RS_16 = 2'd3
  } res_sel_e;

  typedef struct packed {
    logic ovr;
    logic win;
    logic rdy;
  } status_t;

endpackage

// File: rtl/win_operand_norm.sv
module win_operand_norm
  import conv_win_pkg::*;
#(
  parameter int unsigned IN_W  = DATA_W,
  parameter int unsigned OUT_W = CMP_W
) (
  input  logic [IN_W-1:0]         raw,
  input  logic [1:0]              res_sel,
  input  logic                    diff_mode,
  output logic signed [OUT_W-1:0] norm
);

  // Narrow an operand to the active width, then extend it to the
  // common compare width with the sign bit or with zeros.
  localparam int unsigned W8  = 8;
  localparam int unsigned W10 = 10;
  localparam int unsigned W12 = 12;

  logic ext8, ext10, ext12, ext16;

  always_comb begin
    ext8  = diff_mode & raw[W8-1];
    ext10 = diff_mode & raw[W10-1];
    ext12 = diff_mode & raw[W12-1];
    ext16 = diff_mode & raw[IN_W-1];
  end

  always_comb begin
    case (res_sel_e'(res_sel))
      RS_8:    norm = {{(OUT_W-W8){ext8}},   raw[W8-1:0]};
      RS_10:   norm = {{(OUT_W-W10){ext10}}, raw[W10-1:0]};
      RS_12:   norm = {{(OUT_W-W12){ext12}}, raw[W12-1:0]};
      default: norm = {{(OUT_W-IN_W){ext16}}, raw};
    endcase
  end

endmodule

// File: rtl/win_cond_eval.sv
module win_cond_eval
  import conv_win_pkg::*;
#(
  parameter int unsigned W = CMP_W
) (
  input  logic signed [W-1:0] res_n,
  input  logic signed [W-1:0] lo_n,
  input  logic signed [W-1:0] hi_n,
  input  logic [2:0]          mode,
  output logic                hit
);

  logic gt_lo;
  logic lt_hi;

  always_comb begin
    gt_lo = res_n > lo_n;
    lt_hi = res_n < hi_n;
  end

  always_comb begin
    case (win_mode_e'(mode))
      WM_ABOVE:   hit = gt_lo;
      WM_BELOW:   hit = lt_hi;
      WM_INSIDE:  hit = gt_lo & lt_hi;
      WM_OUTSIDE: hit = ~(gt_lo & lt_hi);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/win_flag_ctrl.sv
module win_flag_ctrl
  import conv_win_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [W-1:0]  res_data,
  input  logic          hit,
  input  logic          win_evt_en,
  input  logic          rdy_evt_en,
  input  logic          res_read,
  input  logic          clr_we,
  input  logic [ST_W-1:0] clr_bits,
  output status_t       st_q,
  output logic          win_evt_q,
  output logic          rdy_evt_q,
  output logic [W-1:0]  res_q
);

  status_t     st_d;
  logic        win_evt_d;
  logic        rdy_evt_d;
  logic        res_en;
  logic [ST_W-1:0] clr_m;
  logic        set_rdy, set_win, set_ovr;

  // Next-state logic; a set always wins over a clear.
  always_comb begin
    clr_m     = clr_we ? clr_bits : '0;
    set_rdy   = res_valid;
    set_win   = res_valid & hit;
    set_ovr   = res_valid & st_q.rdy & ~res_read;
    st_d.rdy  = set_rdy | (st_q.rdy & ~res_read & ~clr_m[ST_RDY]);
    st_d.win  = set_win | (st_q.win & ~clr_m[ST_WIN]);
    st_d.ovr  = set_ovr | (st_q.ovr & ~clr_m[ST_OVR]);
    win_evt_d = set_win & win_evt_en;
    rdy_evt_d = set_rdy & rdy_evt_en;
    res_en    = res_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      win_evt_q <= 1'b0;
      rdy_evt_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      win_evt_q <= win_evt_d;
      rdy_evt_q <= rdy_evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_data;
    end
  end

endmodule

// File: rtl/conv_window_monitor.sv
module conv_window_monitor
  import conv_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_valid,
  input  logic [15:0] res_data,
  input  logic [2:0]  win_mode,
  input  logic [15:0] thr_lo,
  input  logic [15:0] thr_hi,
  input  logic [1:0]  res_sel,
  input  logic        diff_mode,
  input  logic        win_evt_en,
  input  logic        rdy_evt_en,
  input  logic        res_read,
  input  logic        clr_we,
  input  logic [2:0]  clr_bits,
  output logic [2:0]  status,
  output logic        win_evt,
  output logic        rdy_evt,
  output logic [15:0] res_held
);

  localparam int unsigned N_OPS  = 3;
  localparam int unsigned OP_RES = 0;
  localparam int unsigned OP_LO  = 1;
  localparam int unsigned OP_HI  = 2;

  logic [DATA_W-1:0]        op_raw  [N_OPS];
  logic signed [CMP_W-1:0]  op_norm [N_OPS];
  logic                     hit;
  status_t                  st_q;

  always_comb begin
    op_raw[OP_RES] = res_data;
    op_raw[OP_LO]  = thr_lo;
    op_raw[OP_HI]  = thr_hi;
  end

  for (genvar g = 0; g < N_OPS; g++) begin : g_norm
    win_operand_norm #(
      .IN_W  (DATA_W),
      .OUT_W (CMP_W)
    ) u_norm (
      .raw       (op_raw[g]),
      .res_sel   (res_sel),
      .diff_mode (diff_mode),
      .norm      (op_norm[g])
    );
  end

  win_cond_eval #(
    .W (CMP_W)
  ) u_eval (
    .res_n (op_norm[OP_RES]),
    .lo_n  (op_norm[OP_LO]),
    .hi_n  (op_norm[OP_HI]),
    .mode  (win_mode),
    .hit   (hit)
  );

  win_flag_ctrl #(
    .W (DATA_W)
  ) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .hit        (hit),
    .win_evt_en (win_evt_en),
    .rdy_evt_en (rdy_evt_en),
    .res_read   (res_read),
    .clr_we     (clr_we),
    .clr_bits   (clr_bits),
    .st_q       (st_q),
    .win_evt_q  (win_evt),
    .rdy_evt_q  (rdy_evt),
    .res_q      (res_held)
  );

  assign status = st_q;

endmodule

// File: rtl/conv_window_monitor_chk.sv
module conv_window_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        res_valid,
  input logic [15:0] res_data,
  input logic [2:0]  win_mode,
  input logic        win_evt_en,
  input logic        rdy_evt_en,
  input logic        res_read,
  input logic [2:0]  status,
  input logic        win_evt,
  input logic        rdy_evt,
  input logic [15:0] res_held
);

  AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (win_mode == 3'd0 || win_mode > 3'd4)) |=> !win_evt); // R2

  AST_EVT_SETS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |-> status[1]); // R8

  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !win_evt_en) |=> !win_evt); // R8

  AST_RDY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> status[0]); // R9

  AST_RDY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && rdy_evt_en) |=> rdy_evt); // R9

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && status[0] && !res_read) |=> status[2]); // R10

  AST_HELD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (res_held == $past(res_data))); // R12

endmodule

bind conv_window_monitor conv_window_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .win_mode   (win_mode),
  .win_evt_en (win_evt_en),
  .rdy_evt_en (rdy_evt_en),
  .res_read   (res_read),
  .status     (status),
  .win_evt    (win_evt),
  .rdy_evt    (rdy_evt),
  .res_held   (res_held)
);

// File: tb/conv_window_monitor_bench.sv
module conv_window_monitor_bench;

  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_data;
  logic [2:0]  win_mode;
  logic [15:0] thr_lo;
  logic [15:0] thr_hi;
  logic [1:0]  res_sel;
  logic        diff_mode;
  logic        win_evt_en;
  logic        rdy_evt_en;
  logic        res_read;
  logic        clr_we;
  logic [2:0]  clr_bits;
  logic [2:0]  status;
  logic        win_evt;
  logic        rdy_evt;
  logic [15:0] res_held;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  conv_window_monitor u_conv_window_monitor (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int width_of(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic int to_val(input logic [15:0] raw, input logic [1:0] s, input logic d);
    int w = width_of(s);
    int v = int'(raw) & ((1 << w) - 1);
    if (d && v >= (1 << (w - 1))) v = v - (1 << w);
    return v;
  endfunction

  function automatic bit model_hit(input logic [2:0] m, input logic [15:0] r,
                                   input logic [15:0] lo, input logic [15:0] hi,
                                   input logic [1:0] s, input logic d);
    int rv = to_val(r, s, d);
    int lv = to_val(lo, s, d);
    int hv = to_val(hi, s, d);
    case (m)
      3'd1: return rv > lv;
      3'd2: return rv < hv;
      3'd3: return (rv > lv) && (rv < hv);
      3'd4: return !((rv > lv) && (rv < hv));
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the falling edge after the result edge.
  task automatic conv(input logic [15:0] r);
    res_valid = 1'b1;
    res_data  = r;
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_all();
    clr_we   = 1'b1;
    clr_bits = 3'b111;
    @(posedge clk);
    @(negedge clk);
    clr_we   = 1'b0;
    clr_bits = 3'b000;
  endtask

  task automatic cfg(input logic [2:0] m, input logic [15:0] lo, input logic [15:0] hi,
                     input logic [1:0] s, input logic d);
    win_mode = m; thr_lo = lo; thr_hi = hi; res_sel = s; diff_mode = d;
  endtask

  initial begin
    rst_n = 1'b0; res_valid = 0; res_data = '0; win_mode = 0; thr_lo = '0; thr_hi = '0;
    res_sel = 2'd2; diff_mode = 0; win_evt_en = 1; rdy_evt_en = 1; res_read = 0;
    clr_we = 0; clr_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(status == 3'b000, "R1 status", status, 0);
    check(win_evt == 0 && rdy_evt == 0, "R1 events", {win_evt, rdy_evt}, 0);
    check(res_held == 16'h0, "R1 held", res_held, 0);

    // R3 strict above-lower, R8 timing, R10 overrun
    cfg(3'd1, 16'd100, 16'd0, 2'd2, 1'b0);
    conv(16'd100);
    check(win_evt == 0, "R3 equal not above", win_evt, 0);
    check(rdy_evt == 1, "R9 ready event", rdy_evt, 1);
    conv(16'd101);
    check(win_evt == 1, "R3 above hit", win_evt, 1);
    check(status == 3'b111, "R10 overrun and R8 window set", status, 3'b111);
    @(negedge clk);
    check(win_evt == 0, "R8 event one cycle", win_evt, 0);
    check(status[1] == 1, "R8 window sticky", status[1], 1);
    check(res_held == 16'd101, "R12 held result", res_held, 101);

    // R11 clear
    clear_all();
    check(status == 3'b000, "R11 w1c clears", status, 0);

    // R9 read clears ready
    conv(16'd5);
    check(status[0] == 1, "R9 ready set", status[0], 1);
    res_read = 1; @(posedge clk); @(negedge clk); res_read = 0;
    check(status[0] == 0, "R9 read clears ready", status[0], 0);

    // R10 read in same cycle as new result: no overrun
    conv(16'd6);
    res_read = 1; res_valid = 1; res_data = 16'd7;
    @(posedge clk); @(negedge clk);
    res_read = 0; res_valid = 0;
    check(status[2] == 0, "R10 no overrun when read", status[2], 0);
    check(status[0] == 1, "R9 new result keeps ready", status[0], 1);

    // R11 set wins over clear
    clear_all();
    clr_we = 1; clr_bits = 3'b011; res_valid = 1; res_data = 16'd200;
    @(posedge clk); @(negedge clk);
    clr_we = 0; clr_bits = 0; res_valid = 0;
    check(status[1:0] == 2'b11, "R11 set wins", status, 3);
    clear_all();

    // R4 below-upper
    cfg(3'd2, 16'd0, 16'd50, 2'd2, 1'b0);
    conv(16'd50);  check(win_evt == 0, "R4 equal not below", win_evt, 0);
    conv(16'd49);  check(win_evt == 1, "R4 below hit", win_evt, 1);

    // R5 inside / outside
    cfg(3'd3, 16'd10, 16'd20, 2'd2, 1'b0);
    conv(16'd10);  check(win_evt == 0, "R5 inside lower edge", win_evt, 0);
    conv(16'd15);  check(win_evt == 1, "R5 inside hit", win_evt, 1);
    conv(16'd20);  check(win_evt == 0, "R5 inside upper edge", win_evt, 0);
    win_mode = 3'd4;
    conv(16'd10);  check(win_evt == 1, "R5 outside edge hit", win_evt, 1);
    conv(16'd15);  check(win_evt == 0, "R5 outside miss", win_evt, 0);

    // R6/R7 8-bit sign from bit 7
    cfg(3'd1, 16'h0180, 16'd0, 2'd0, 1'b1);
    conv(16'h0000); check(win_evt == 1, "R7 8-bit diff sign bit 7", win_evt, 1);
    diff_mode = 0;
    conv(16'h0000); check(win_evt == 0, "R6 8-bit unsigned", win_evt, 0);
    conv(16'h01FF); check(win_evt == 1, "R7 8-bit masks result", win_evt, 1);

    // R6 16-bit signed vs unsigned
    cfg(3'd1, 16'h0000, 16'd0, 2'd3, 1'b1);
    conv(16'h8000); check(win_evt == 0, "R6 16-bit negative", win_evt, 0);
    diff_mode = 0;
    conv(16'h8000); check(win_evt == 1, "R6 16-bit unsigned", win_evt, 1);

    // R7 10-bit vs 12-bit threshold masking
    cfg(3'd1, 16'h0405, 16'd0, 2'd1, 1'b0);
    conv(16'd6); check(win_evt == 1, "R7 10-bit mask", win_evt, 1);
    res_sel = 2'd2;
    conv(16'd6); check(win_evt == 0, "R7 12-bit mask", win_evt, 0);

    // R2 disabled modes
    clear_all();
    cfg(3'd0, 16'd0, 16'hFFFF, 2'd3, 1'b0);
    conv(16'd5); check(win_evt == 0 && status[1] == 0, "R2 mode 0 quiet", status, 1);
    win_mode = 3'd6;
    conv(16'd5); check(win_evt == 0 && status[1] == 0, "R2 mode 6 quiet", status, 1);

    // R8 event enable off
    cfg(3'd2, 16'd0, 16'd100, 2'd2, 1'b0);
    win_evt_en = 0; rdy_evt_en = 0;
    conv(16'd1);
    check(win_evt == 0 && status[1] == 1, "R8 event disabled, flag set", {win_evt, status[1]}, 1);
    check(rdy_evt == 0, "R9 ready event disabled", rdy_evt, 0);
    win_evt_en = 1; rdy_evt_en = 1;

    // Random: R6 R7 comparisons against model
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      bit e;
      cfg(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      if (i % 5 == 0) thr_hi = thr_lo;
      r = 16'($urandom);
      e = model_hit(win_mode, r, thr_lo, thr_hi, res_sel, diff_mode);
      conv(r);
      check(win_evt == e, "R6 R7 random compare", win_evt, e);
      check(res_held == r, "R12 random held", res_held, r);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule